// File: doc/BRIEF.md
# Vectored Prioritized Interrupt Controller

This block gathers up to 64 interrupt inputs, arranged in two banks of 32. A rising edge on an input sets a pending flag for that input. The flag stays set until software clears it by writing a 1 to its bit. Each input has an enable bit and a 3-bit priority. Among the inputs that are both enabled and pending, the block picks one winner and computes an entry address for it. The address is a programmable base plus four times (winner index + 1). A CPU reads this address through a simple 32-bit register bus and can jump straight to a handler slot.

Priority values 0 and 1 form the fast class, which drives `fiq_o`. Values 2 to 7 form the normal class, which drives `irq_o`. A lower value is more urgent. When two winners have the same value, the lower input index wins.

The winner, the entry address and both request outputs are registered. Each follows a change to the pending, enable or priority state by one clock. Bus reads return data one clock after the address is presented. Writes take effect on the clock edge where `bus_wr` is high.

Top module: `vec_intc`

## Requirements
- R1: A pending flag is set only by a 0-to-1 transition of its input. An input held high after its flag is cleared does not set the flag again.
- R2: Writing the fast-pending register of a bank (offset 0x00 for bank 0, 0x04 for bank 1) or the normal-pending register of a bank (0x08, 0x0C) clears every flag of that bank whose data bit is 1. Data bits at 0 leave their flags unchanged. A read of the fast-pending register shows the pending flags of inputs with priority 0 or 1. A read of the normal-pending register shows the pending flags of inputs with priority 2 to 7.
- R3: Bit i of the enable register at 0x18 (inputs 0 to 31) or at 0x1C (inputs 32 to 63) enables input i when it is 1. A pending input whose enable bit is 0 takes no part in selection and raises no request. Its pending flag is kept.
- R4: Input n's priority is held in the priority register at 0x30 + 4*(n/8), bits [4*(n%8)+2 : 4*(n%8)]. Bit 4*(n%8)+3 of that register reads 0 and ignores writes.
- R5: The entry register at 0x14 reads base + 4*(w+1), where w is the winner. The winner is the enabled pending input with the lowest priority value; on a tie, the lowest index wins.
- R6: `fiq_o` is high when any enabled pending input has priority 0 or 1. `irq_o` is high when any enabled pending input has priority 2 to 7. The two outputs are independent of each other.
- R7: When no enabled input is pending, the entry register reads exactly the base, and both request outputs are low.
- R8: If a rising edge and a clearing write reach the same input in the same cycle, the flag ends set.
- R9: After reset, all pending flags are 0, all enables are 0, every priority is 7, and the control register (0x20) and the base register (0x24) are 0.
- R10: The request outputs and the entry value change one clock after the pending, enable or priority state changes.
- R11: The control register (0x20) and the base register (0x24) read back the last 32-bit value written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | 64 | Interrupt inputs, synchronous to clk |
| bus_addr | input | 8 | Byte address of the register access |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the address of the previous cycle |
| fiq_o | output | 1 | Fast-class request |
| irq_o | output | 1 | Normal-class request |

## Verification
Two functions can fall in the same cycle: the edge latch setting an input's flag, and a pending-register write clearing that same flag. The bench forces this collision on purpose in a directed case. It also produces it at random, because random input toggles and random clear masks often hit the same bit in one step. The bench judges each collision against a model in which a new edge beats the clear. It then reads the pending register and the request outputs, so a lost event shows up as a mismatch.

// File: rtl/vic_pkg.sv
package vic_pkg;
  localparam int REG_W    = 32;
  localparam int BANK_W   = 32;
  localparam int PRIO_W   = 3;
  localparam int NIB_W    = 4;
  localparam int PER_PREG = REG_W / NIB_W;
  localparam int FAST_MAX = 1;

  localparam int A_FPEND0 = 'h00;
  localparam int A_NPEND0 = 'h08;
  localparam int A_ENTRY  = 'h14;
  localparam int A_EN0    = 'h18;
  localparam int A_CTRL   = 'h20;
  localparam int A_BASE   = 'h24;
  localparam int A_PRIO0  = 'h30;
endpackage

// File: rtl/vic_pending.sv
module vic_pending #(
  parameter int NUM_SRC = 64
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic [NUM_SRC-1:0] clr_i,
  output logic [NUM_SRC-1:0] pend_o
);
  logic [NUM_SRC-1:0] src_q, pend_q, rise;

  assign rise   = src_i & ~src_q;
  assign pend_o = pend_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      src_q  <= '0;
      pend_q <= '0;
    end else begin
      src_q  <= src_i;
      pend_q <= (pend_q & ~clr_i) | rise;
    end
  end

  assert_set_R1: assert property (@(posedge clk) disable iff (rst)
    (|rise) |=> ((pend_q & $past(rise)) == $past(rise)));
  assert_clr_R2: assert property (@(posedge clk) disable iff (rst)
    (|(clr_i & ~rise)) |=> ((pend_q & $past(clr_i & ~rise)) == '0));
  assert_keep_R8: assert property (@(posedge clk) disable iff (rst)
    (|(clr_i & rise)) |=> ((pend_q & $past(clr_i & rise)) == $past(clr_i & rise)));
endmodule

// File: rtl/vic_arbiter.sv
module vic_arbiter #(
  parameter int NUM_SRC  = 64,
  parameter int PRIO_W   = 3,
  parameter int FAST_MAX = 1,
  parameter int IDX_W    = $clog2(NUM_SRC)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [NUM_SRC-1:0]        pend_i,
  input  logic [NUM_SRC-1:0]        en_i,
  input  logic [NUM_SRC*PRIO_W-1:0] prio_i,
  output logic [NUM_SRC-1:0]        fast_o,
  output logic                      win_valid_o,
  output logic [IDX_W-1:0]          win_idx_o,
  output logic                      fiq_o,
  output logic                      irq_o
);
  logic [NUM_SRC-1:0] cand;
  logic               found;
  logic [PRIO_W-1:0]  best;
  logic [IDX_W-1:0]   idx;

  genvar gi;
  generate
    for (gi = 0; gi < NUM_SRC; gi++) begin : g_class
      assign fast_o[gi] = prio_i[gi*PRIO_W +: PRIO_W] <= PRIO_W'(FAST_MAX);
    end
  endgenerate

  assign cand = pend_i & en_i;

  always_comb begin
    found = 1'b0;
    best  = '1;
    idx   = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (cand[i] && (!found || prio_i[i*PRIO_W +: PRIO_W] <= best)) begin
        found = 1'b1;
        best  = prio_i[i*PRIO_W +: PRIO_W];
        idx   = IDX_W'(i);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      win_valid_o <= 1'b0;
      win_idx_o   <= '0;
      fiq_o       <= 1'b0;
      irq_o       <= 1'b0;
    end else begin
      win_valid_o <= found;
      win_idx_o   <= idx;
      fiq_o       <= |(cand & fast_o);
      irq_o       <= |(cand & ~fast_o);
    end
  end

  assert_idle_R7: assert property (@(posedge clk) disable iff (rst)
    !(|(pend_i & en_i)) |=> (!fiq_o && !irq_o && !win_valid_o));
endmodule

// File: rtl/vec_intc.sv
module vec_intc
  import vic_pkg::*;
#(
  parameter int NUM_BANKS = 2,
  parameter int ADDR_W    = 8
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic [NUM_BANKS*BANK_W-1:0]    src_i,
  input  logic [ADDR_W-1:0]              bus_addr,
  input  logic                           bus_wr,
  input  logic [REG_W-1:0]               bus_wdata,
  output logic [REG_W-1:0]               bus_rdata,
  output logic                           fiq_o,
  output logic                           irq_o
);
  localparam int NUM_SRC = NUM_BANKS * BANK_W;
  localparam int IDX_W   = $clog2(NUM_SRC);
  localparam int NUM_PR  = NUM_SRC / PER_PREG;

  logic [NUM_SRC-1:0]        pend, en_q, clr, fast;
  logic [NUM_SRC*PRIO_W-1:0] prio_q;
  logic [REG_W-1:0]          ctrl_q, base_q, entry_val, rd_mux;
  logic                      win_valid;
  logic [IDX_W-1:0]          win_idx;
  logic                      unused_wdata;

  assign unused_wdata = ^bus_wdata;

  function automatic logic hit(input logic [ADDR_W-1:0] a, input int ofs);
    return a == ADDR_W'(ofs);
  endfunction

  always_comb begin
    clr = '0;
    for (int b = 0; b < NUM_BANKS; b++)
      if (bus_wr && (hit(bus_addr, A_FPEND0 + 4*b) || hit(bus_addr, A_NPEND0 + 4*b)))
        clr[b*BANK_W +: BANK_W] = bus_wdata;
  end

  vic_pending #(.NUM_SRC(NUM_SRC)) u_pend (
    .clk(clk), .rst(rst), .src_i(src_i), .clr_i(clr), .pend_o(pend)
  );

  vic_arbiter #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .FAST_MAX(FAST_MAX), .IDX_W(IDX_W)) u_arb (
    .clk(clk), .rst(rst), .pend_i(pend), .en_i(en_q), .prio_i(prio_q),
    .fast_o(fast), .win_valid_o(win_valid), .win_idx_o(win_idx),
    .fiq_o(fiq_o), .irq_o(irq_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= '0;
      ctrl_q <= '0;
      base_q <= '0;
      prio_q <= '1;
    end else if (bus_wr) begin
      for (int b = 0; b < NUM_BANKS; b++)
        if (hit(bus_addr, A_EN0 + 4*b)) en_q[b*BANK_W +: BANK_W] <= bus_wdata;
      if (hit(bus_addr, A_CTRL)) ctrl_q <= bus_wdata;
      if (hit(bus_addr, A_BASE)) base_q <= bus_wdata;
      for (int k = 0; k < NUM_PR; k++)
        if (hit(bus_addr, A_PRIO0 + 4*k))
          for (int j = 0; j < PER_PREG; j++)
            prio_q[(k*PER_PREG+j)*PRIO_W +: PRIO_W] <= bus_wdata[j*NIB_W +: PRIO_W];
    end
  end

  assign entry_val = base_q + (win_valid ? ((REG_W'(win_idx) + REG_W'(1)) << 2) : '0);

  always_comb begin
    rd_mux = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (hit(bus_addr, A_FPEND0 + 4*b)) rd_mux = pend[b*BANK_W +: BANK_W] & fast[b*BANK_W +: BANK_W];
      if (hit(bus_addr, A_NPEND0 + 4*b)) rd_mux = pend[b*BANK_W +: BANK_W] & ~fast[b*BANK_W +: BANK_W];
      if (hit(bus_addr, A_EN0 + 4*b))    rd_mux = en_q[b*BANK_W +: BANK_W];
    end
    if (hit(bus_addr, A_ENTRY)) rd_mux = entry_val;
    if (hit(bus_addr, A_CTRL))  rd_mux = ctrl_q;
    if (hit(bus_addr, A_BASE))  rd_mux = base_q;
    for (int k = 0; k < NUM_PR; k++)
      if (hit(bus_addr, A_PRIO0 + 4*k))
        for (int j = 0; j < PER_PREG; j++)
          rd_mux[j*NIB_W +: NIB_W] = {1'b0, prio_q[(k*PER_PREG+j)*PRIO_W +: PRIO_W]};
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rd_mux;
  end

  assert_mask_R3: assert property (@(posedge clk) disable iff (rst)
    (fiq_o || irq_o) |-> $past(|(pend & en_q)));
  assert_lat_R10: assert property (@(posedge clk) disable iff (rst)
    (!$past(|(pend & en_q))) |-> !(fiq_o || irq_o));
endmodule

// File: tb/test_vec_intc.sv
`timescale 1ns/1ps
module test_vec_intc;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] src = '0;
  logic [7:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        fiq_o, irq_o;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  logic [63:0] m_src = '0, m_pend = '0, m_en = '0;
  logic [2:0]  m_prio [64];
  logic [31:0] m_ctrl = '0, m_base = '0;

  always #2 clk = ~clk;

  vec_intc i_vec_intc (
    .clk(clk), .rst(rst), .src_i(src), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .fiq_o(fiq_o), .irq_o(irq_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_entry();
    int w = -1;
    for (int i = 63; i >= 0; i--)
      if (m_pend[i] && m_en[i] && (w < 0 || m_prio[i] <= m_prio[w])) w = i;
    return (w < 0) ? m_base : m_base + 32'((w + 1) * 4);
  endfunction

  function automatic logic exp_req(input bit fast);
    logic r = 1'b0;
    for (int i = 0; i < 64; i++)
      if (m_pend[i] && m_en[i] && ((m_prio[i] <= 3'd1) == fast)) r = 1'b1;
    return r;
  endfunction

  function automatic logic [31:0] exp_pend(input bit fast, input int b);
    logic [31:0] r = '0;
    for (int i = 0; i < 32; i++)
      r[i] = m_pend[b*32+i] && ((m_prio[b*32+i] <= 3'd1) == fast);
    return r;
  endfunction

  task automatic model(input logic [63:0] ns, input bit w, input logic [7:0] a, input logic [31:0] d);
    logic [63:0] clr = '0;
    if (w) begin
      if (a == 8'h00 || a == 8'h08) clr[31:0]  = d;
      if (a == 8'h04 || a == 8'h0C) clr[63:32] = d;
      if (a == 8'h18) m_en[31:0]  = d;
      if (a == 8'h1C) m_en[63:32] = d;
      if (a == 8'h20) m_ctrl = d;
      if (a == 8'h24) m_base = d;
      if (a >= 8'h30 && a <= 8'h4C && a[1:0] == 2'b00)
        for (int j = 0; j < 8; j++) m_prio[(a - 8'h30) / 4 * 8 + j] = d[j*4 +: 3];
    end
    m_pend = (m_pend & ~clr) | (ns & ~m_src);
    m_src = ns;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a;
    @(negedge clk); d = bus_rdata;
  endtask

  task automatic check_out(input string req);
    logic [31:0] d;
    check({req, " fiq"}, 32'(fiq_o), 32'(exp_req(1'b1)));
    check({req, " irq"}, 32'(irq_o), 32'(exp_req(1'b0)));
    rd(8'h14, d);
    check({req, " entry"}, d, exp_entry());
  endtask

  task automatic step(input logic [63:0] ns, input bit w, input logic [7:0] a,
                      input logic [31:0] d, input string req);
    @(negedge clk); src = ns; bus_wr = w; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
    model(ns, w, a, d);
    @(negedge clk);
    check_out(req);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [63:0] ns;
    void'($urandom(32'd4242));
    for (int i = 0; i < 64; i++) m_prio[i] = 3'd7;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R9: reset state
    rd(8'h18, d); check("R9 en0", d, 32'h0);
    rd(8'h1C, d); check("R9 en1", d, 32'h0);
    rd(8'h30, d); check("R9 prio0", d, 32'h77777777);
    rd(8'h4C, d); check("R9 prio7", d, 32'h77777777);
    rd(8'h20, d); check("R9 ctrl", d, 32'h0);
    rd(8'h24, d); check("R9 base", d, 32'h0);
    check_out("R9");

    // R11: ctrl and base readback
    step(m_src, 1'b1, 8'h20, 32'hA5A5_0F0F, "R11");
    rd(8'h20, d); check("R11 ctrl", d, 32'hA5A5_0F0F);
    step(m_src, 1'b1, 8'h20, 32'h0, "R11");

    // R4: priority field layout, bit 3 of each nibble reads 0
    step(m_src, 1'b1, 8'h30, 32'hFFFF_FFFF, "R4");
    rd(8'h30, d); check("R4 mask", d, 32'h77777777);

    // R10: one-clock latency, R5/R6 normal-class winner
    step(m_src, 1'b1, 8'h18, 32'h0000_0020, "R3");
    @(negedge clk); src = 64'h20;
    @(negedge clk);
    check("R10 before", 32'(irq_o), 32'h0);
    @(negedge clk);
    check("R10 after", 32'(irq_o), 32'h1);
    model(64'h20, 1'b0, 8'h0, 32'h0);
    check_out("R5 R6");
    rd(8'h14, d); check("R5 idx5", d, 32'd24);

    // R1: held-high level does not reset the flag once cleared
    step(m_src, 1'b1, 8'h08, 32'h20, "R1");
    rd(8'h08, d); check("R1 pend", d, 32'h0);
    check("R1 irq", 32'(irq_o), 32'h0);
    step(64'h0, 1'b0, 8'h0, 32'h0, "R1");

    // R5: tie at priority 0 between inputs 10 and 12, lower index wins; R6 fast class
    step(m_src, 1'b1, 8'h34, 32'h77707077, "R4");
    step(m_src, 1'b1, 8'h18, 32'h0000_1420, "R3");
    step(64'h1400, 1'b0, 8'h0, 32'h0, "R5 tie");
    rd(8'h14, d); check("R5 tie idx10", d, 32'd44);
    check("R6 fiq", 32'(fiq_o), 32'h1);
    rd(8'h00, d); check("R2 fpend read", d, 32'h1400);

    // R2: write of zeros changes nothing, ones clear
    step(m_src, 1'b1, 8'h00, 32'h0, "R2 zero");
    rd(8'h00, d); check("R2 zero", d, 32'h1400);
    step(m_src, 1'b1, 8'h00, 32'h0400, "R2 one");
    rd(8'h00, d); check("R2 one", d, 32'h1000);

    // R8: clear and new edge in the same cycle
    step(m_src & ~64'h1000, 1'b0, 8'h0, 32'h0, "R8 prep");
    step(m_src | 64'h1000, 1'b1, 8'h00, 32'h1000, "R8");
    rd(8'h00, d); check("R8 kept", d, 32'h1000);

    // R3: disable stops request, flag kept
    step(m_src, 1'b1, 8'h18, 32'h0, "R3 off");
    check("R3 fiq", 32'(fiq_o), 32'h0);
    rd(8'h00, d); check("R3 pend kept", d, 32'h1000);

    // R7: idle returns base
    step(m_src, 1'b1, 8'h24, 32'h0000_1000, "R7");
    rd(8'h14, d); check("R7 base", d, 32'h0000_1000);

    // Random phase covering all requirements against the model
    for (int it = 0; it < 400; it++) begin
      int op;
      logic [7:0] a;
      logic [31:0] wd;
      ns = m_src ^ ({$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom});
      op = $urandom_range(0, 5);
      wd = $urandom;
      case (op)
        0: a = 8'h00 + 8'($urandom_range(0, 3) * 4);
        1: a = 8'h18 + 8'($urandom_range(0, 1) * 4);
        2: a = 8'h30 + 8'($urandom_range(0, 7) * 4);
        3: a = 8'h24;
        default: a = 8'h00;
      endcase
      step(ns, op < 4, a, wd, "R1 R2 R3 R5 R6 R8 rand");
      if (it % 16 == 0) begin
        for (int b = 0; b < 2; b++) begin
          rd(8'(b * 4), d);     check("R2 rand fpend", d, exp_pend(1'b1, b));
          rd(8'(8 + b * 4), d); check("R2 rand npend", d, exp_pend(1'b0, b));
        end
      end
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule